// File: doc/BRIEF.md
# Microcoded Accumulator CPU

This block is a small, self-contained processor. An accumulator datapath (accumulator, data register, address register, program counter) and a 2048-word, 16-bit main memory are steered by a 128-word, 20-bit control store. Each control word holds three 3-bit operation fields, a 2-bit condition select, a 2-bit branch kind and a 7-bit next address. A sequencer picks the next microaddress from one of four sources: the incremented microaddress, the branch address, a one-deep return register, or an address mapped from the opcode.

Machine instructions are 16 bits wide. Bit 15 asks for indirect addressing, bits 14:11 give the opcode and bits 10:0 give the address. Four opcodes are implemented: 0 adds memory to the accumulator, 1 branches when the accumulator is negative, 2 stores the accumulator, and 3 swaps the accumulator with memory. Every routine reaches a shared indirect-address subroutine through a conditional call. The only outside access is a preload/inspect port on main memory. The accumulator, program counter and microaddress are brought out so they can be observed.

Top module: `acc_ucpu`

## Requirements
- R1: While rst_n is low and after its release, AC and PC read 0 and the microaddress reads 64 until the first clock edge with rst_n high.
- R2: Every instruction starts with microaddresses 64, 65, 66, and the next microaddress is 4 times the opcode. Opcode 0 runs 0,1,2; opcode 1 runs 4 then 5 (not taken) or 6,7 (taken); opcode 2 runs 8,9,10; opcode 3 runs 12,13,14,15. After the routine's last word the microaddress returns to 64.
- R3: Opcode 0 sets AC to (AC + M[EA]) mod 2^16.
- R4: Opcode 1 sets PC to EA when AC bit 15 is 1. Otherwise PC keeps the address that follows the instruction. AC is unchanged either way.
- R5: Opcode 2 writes AC to M[EA] and leaves AC unchanged.
- R6: Opcode 3 loads AC with the old M[EA] and writes the old AC to M[EA] in the same instruction.
- R7: With bit 15 set, EA is bits 10:0 of M[address field], and the upper bits of that pointer word are ignored. The routine's conditional call inserts microaddresses 67, 68 and then resumes at the word after the call. With bit 15 clear, EA is the address field and no call is made.
- R8: When tb_we is high at a clock edge, tb_wdata is written to M[tb_waddr], and this write takes precedence over a processor write. tb_rdata always shows M[tb_raddr] combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| tb_we | input | 1 | Memory write strobe from the preload port |
| tb_waddr | input | 11 | Preload write address |
| tb_wdata | input | 16 | Preload write data |
| tb_raddr | input | 11 | Inspect read address |
| tb_rdata | output | 16 | Memory word at tb_raddr |
| ac_o | output | 16 | Accumulator |
| pc_o | output | 11 | Program counter |
| uaddr_o | output | 7 | Current control-store address |

## Verification
The assertions check, on every cycle, the fixed fetch order 64→65→66 and the aligned, low-half target of the opcode mapping. They also check that the return from the indirect subroutine lands on one of the four resume words, that the program counter moves only in the increment and jump words, and that the fetch, branch, store and indirect words leave the accumulator alone. The arithmetic results, the branch decision, the stored and swapped memory words, and the masking of the pointer's upper bits can be shown only by the bench's scenarios. There, a preloaded program runs against a behavioural model that predicts every microaddress and the state at each instruction boundary.

// File: rtl/ucpu_pkg.sv
`timescale 1ns/1ps
package ucpu_pkg;
  localparam int DW  = 16;           // data word
  localparam int AW  = 11;           // main memory address
  localparam int OPW = 4;            // opcode width
  localparam int UAW = 7;            // control-store address
  localparam int UWW = 3 + 3 + 3 + 2 + 2 + UAW;
  localparam int MEM_WORDS = 1 << AW;

  typedef enum logic [2:0] {
    A_NOP, A_ADD, A_CLRAC, A_INCAC, A_DR2AC, A_DR2AR, A_PC2AR, A_WRITE
  } f1_e;
  typedef enum logic [2:0] {
    B_NOP, B_SUB, B_OR, B_AND, B_READ, B_AC2DR, B_INCDR, B_PC2DR
  } f2_e;
  typedef enum logic [2:0] {
    C_NOP, C_XOR, C_COM, C_SHL, C_SHR, C_INCPC, C_AR2PC, C_RSVD
  } f3_e;
  typedef enum logic [1:0] {COND_ONE, COND_IND, COND_NEG, COND_ZERO} cd_e;
  typedef enum logic [1:0] {NX_JUMP, NX_CALL, NX_RET, NX_MAP} br_e;

  typedef struct packed {
    f1_e            f1;
    f2_e            f2;
    f3_e            f3;
    cd_e            cd;
    br_e            br;
    logic [UAW-1:0] ad;
  } uword_t;

  localparam logic [UAW-1:0] FETCH_UA = 7'd64;
  localparam logic [UAW-1:0] INDIR_UA = 7'd67;

  function automatic uword_t mk(input f1_e a, input f2_e b, input f3_e c,
                                input cd_e d, input br_e e, input logic [UAW-1:0] t);
    uword_t w;
    w.f1 = a; w.f2 = b; w.f3 = c; w.cd = d; w.br = e; w.ad = t;
    return w;
  endfunction
endpackage

// File: rtl/ucpu_ctrl_rom.sv
`timescale 1ns/1ps
module ucpu_ctrl_rom
  import ucpu_pkg::*;
(
  input  logic [UAW-1:0] ua,
  output uword_t         word
);
  always_comb begin
    case (ua)
      // opcode 0: accumulate
      7'd0:  word = mk(A_NOP,   B_NOP,   C_NOP,   COND_IND, NX_CALL, INDIR_UA);
      7'd1:  word = mk(A_NOP,   B_READ,  C_NOP,   COND_ONE, NX_JUMP, 7'd2);
      7'd2:  word = mk(A_ADD,   B_NOP,   C_NOP,   COND_ONE, NX_JUMP, FETCH_UA);
      7'd3:  word = mk(A_NOP,   B_NOP,   C_NOP,   COND_ONE, NX_JUMP, FETCH_UA);
      // opcode 1: branch on negative
      7'd4:  word = mk(A_NOP,   B_NOP,   C_NOP,   COND_NEG, NX_JUMP, 7'd6);
      7'd5:  word = mk(A_NOP,   B_NOP,   C_NOP,   COND_ONE, NX_JUMP, FETCH_UA);
      7'd6:  word = mk(A_NOP,   B_NOP,   C_NOP,   COND_IND, NX_CALL, INDIR_UA);
      7'd7:  word = mk(A_NOP,   B_NOP,   C_AR2PC, COND_ONE, NX_JUMP, FETCH_UA);
      // opcode 2: store
      7'd8:  word = mk(A_NOP,   B_NOP,   C_NOP,   COND_IND, NX_CALL, INDIR_UA);
      7'd9:  word = mk(A_NOP,   B_AC2DR, C_NOP,   COND_ONE, NX_JUMP, 7'd10);
      7'd10: word = mk(A_WRITE, B_NOP,   C_NOP,   COND_ONE, NX_JUMP, FETCH_UA);
      7'd11: word = mk(A_NOP,   B_NOP,   C_NOP,   COND_ONE, NX_JUMP, FETCH_UA);
      // opcode 3: swap
      7'd12: word = mk(A_NOP,   B_NOP,   C_NOP,   COND_IND, NX_CALL, INDIR_UA);
      7'd13: word = mk(A_NOP,   B_READ,  C_NOP,   COND_ONE, NX_JUMP, 7'd14);
      7'd14: word = mk(A_DR2AC, B_AC2DR, C_NOP,   COND_ONE, NX_JUMP, 7'd15);
      7'd15: word = mk(A_WRITE, B_NOP,   C_NOP,   COND_ONE, NX_JUMP, FETCH_UA);
      // instruction fetch
      7'd64: word = mk(A_PC2AR, B_NOP,   C_NOP,   COND_ONE, NX_JUMP, 7'd65);
      7'd65: word = mk(A_NOP,   B_READ,  C_INCPC, COND_ONE, NX_JUMP, 7'd66);
      7'd66: word = mk(A_DR2AR, B_NOP,   C_NOP,   COND_ONE, NX_MAP,  7'd0);
      // indirect-address subroutine
      7'd67: word = mk(A_NOP,   B_READ,  C_NOP,   COND_ONE, NX_JUMP, 7'd68);
      7'd68: word = mk(A_DR2AR, B_NOP,   C_NOP,   COND_ONE, NX_RET,  7'd0);
      default: word = uword_t'('0);
    endcase
  end
endmodule

// File: rtl/ucpu_sequencer.sv
`timescale 1ns/1ps
module ucpu_sequencer
  import ucpu_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  uword_t         word,
  input  logic [DW-1:0]  dr,
  input  logic [DW-1:0]  ac,
  output logic [UAW-1:0] car
);
  localparam logic [UAW-1:0] UA_ONE = 1;

  logic [UAW-1:0] sbr, car_inc, car_nxt;
  logic           cond;

  assign car_inc = car + UA_ONE;

  always_comb begin
    case (word.cd)
      COND_ONE: cond = 1'b1;
      COND_IND: cond = dr[DW-1];
      COND_NEG: cond = ac[DW-1];
      default:  cond = (ac == '0);
    endcase
  end

  always_comb begin
    case (word.br)
      NX_JUMP, NX_CALL: car_nxt = cond ? word.ad : car_inc;
      NX_RET:           car_nxt = sbr;
      default:          car_nxt = {1'b0, dr[DW-2 -: OPW], 2'b00};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      car <= FETCH_UA;
      sbr <= '0;
    end else begin
      car <= car_nxt;
      if (word.br == NX_CALL && cond) sbr <= car_inc;
    end
  end
endmodule

// File: rtl/ucpu_datapath.sv
`timescale 1ns/1ps
module ucpu_datapath
  import ucpu_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  uword_t        word,
  input  logic          tb_we,
  input  logic [AW-1:0] tb_waddr,
  input  logic [DW-1:0] tb_wdata,
  input  logic [AW-1:0] tb_raddr,
  output logic [DW-1:0] tb_rdata,
  output logic [DW-1:0] ac,
  output logic [DW-1:0] dr,
  output logic [AW-1:0] pc
);
  localparam logic [DW-1:0] D_ONE = 1;
  localparam logic [AW-1:0] A_ONE = 1;

  logic [DW-1:0] mem [MEM_WORDS];
  logic [AW-1:0] ar, ar_n, pc_n;
  logic [DW-1:0] ac_n, dr_n, rd;

  assign rd       = mem[ar];
  assign tb_rdata = mem[tb_raddr];

  // accumulator: later cases override, so field 1 wins over 2 over 3
  always_comb begin
    ac_n = ac;
    case (word.f3)
      C_XOR:   ac_n = ac ^ dr;
      C_COM:   ac_n = ~ac;
      C_SHL:   ac_n = ac << 1;
      C_SHR:   ac_n = ac >> 1;
      default: ;
    endcase
    case (word.f2)
      B_SUB:   ac_n = ac - dr;
      B_OR:    ac_n = ac | dr;
      B_AND:   ac_n = ac & dr;
      default: ;
    endcase
    case (word.f1)
      A_ADD:   ac_n = ac + dr;
      A_CLRAC: ac_n = '0;
      A_INCAC: ac_n = ac + D_ONE;
      A_DR2AC: ac_n = dr;
      default: ;
    endcase
  end

  always_comb begin
    case (word.f2)
      B_READ:  dr_n = rd;
      B_AC2DR: dr_n = ac;
      B_INCDR: dr_n = dr + D_ONE;
      B_PC2DR: dr_n = {dr[DW-1:AW], pc};
      default: dr_n = dr;
    endcase
    case (word.f1)
      A_DR2AR: ar_n = dr[AW-1:0];
      A_PC2AR: ar_n = pc;
      default: ar_n = ar;
    endcase
    case (word.f3)
      C_INCPC: pc_n = pc + A_ONE;
      C_AR2PC: pc_n = ar;
      default: pc_n = pc;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac <= '0;
      dr <= '0;
      ar <= '0;
      pc <= '0;
    end else begin
      ac <= ac_n;
      dr <= dr_n;
      ar <= ar_n;
      pc <= pc_n;
    end
  end

  always_ff @(posedge clk) begin
    if (tb_we)                          mem[tb_waddr] <= tb_wdata;
    else if (rst_n && word.f1 == A_WRITE) mem[ar]     <= dr;
  end
endmodule

// File: rtl/acc_ucpu.sv
`timescale 1ns/1ps
module acc_ucpu
  import ucpu_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tb_we,
  input  logic [AW-1:0]  tb_waddr,
  input  logic [DW-1:0]  tb_wdata,
  input  logic [AW-1:0]  tb_raddr,
  output logic [DW-1:0]  tb_rdata,
  output logic [DW-1:0]  ac_o,
  output logic [AW-1:0]  pc_o,
  output logic [UAW-1:0] uaddr_o
);
  uword_t        word;
  logic [DW-1:0] dr;

  ucpu_ctrl_rom rom_i (.ua(uaddr_o), .word(word));

  ucpu_sequencer seq_i (
    .clk(clk), .rst_n(rst_n), .word(word), .dr(dr), .ac(ac_o), .car(uaddr_o)
  );

  ucpu_datapath dp_i (
    .clk(clk), .rst_n(rst_n), .word(word),
    .tb_we(tb_we), .tb_waddr(tb_waddr), .tb_wdata(tb_wdata),
    .tb_raddr(tb_raddr), .tb_rdata(tb_rdata),
    .ac(ac_o), .dr(dr), .pc(pc_o)
  );
endmodule

// File: rtl/ucpu_chk.sv
`timescale 1ns/1ps
module ucpu_chk
  import ucpu_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic [UAW-1:0] ua,
  input logic [DW-1:0]  ac,
  input logic [AW-1:0]  pc
);
  localparam logic [AW-1:0] PC_STEP = 1;

  assert_fetch_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ua == 7'd64) |=> (ua == 7'd65));
  assert_fetch_second_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ua == 7'd65) |=> (ua == 7'd66));
  assert_map_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ua == 7'd66) |=> (ua[UAW-1] == 1'b0 && ua[1:0] == 2'b00));
  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ua == 7'd65) |=> (pc == $past(pc) + PC_STEP));
  assert_pc_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ua != 7'd65 && ua != 7'd7) |=> $stable(pc));
  assert_ac_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ua >= 7'd64 || (ua >= 7'd4 && ua <= 7'd11)) |=> $stable(ac));
  assert_return_site_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ua == 7'd68) |=> (ua == 7'd1 || ua == 7'd7 || ua == 7'd9 || ua == 7'd13));
endmodule

bind acc_ucpu ucpu_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ua(uaddr_o), .ac(ac_o), .pc(pc_o)
);

// File: tb/acc_ucpu_tb_top.sv
`timescale 1ns/1ps
module acc_ucpu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tb_we = 1'b0;
  logic [10:0] tb_waddr = '0, tb_raddr = '0;
  logic [15:0] tb_wdata = '0;
  logic [15:0] tb_rdata, ac_o;
  logic [10:0] pc_o;
  logic [6:0]  uaddr_o;

  int    checks = 0, fails = 0;
  int    m_mem [2048];
  int    m_ac = 0, m_pc = 0;
  int    uq [$];
  string last_req = "R1";

  always #2.5 clk = ~clk;

  acc_ucpu dut_i (
    .clk(clk), .rst_n(rst_n), .tb_we(tb_we), .tb_waddr(tb_waddr),
    .tb_wdata(tb_wdata), .tb_raddr(tb_raddr), .tb_rdata(tb_rdata),
    .ac_o(ac_o), .pc_o(pc_o), .uaddr_o(uaddr_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int enc(input int ind, input int op, input int a);
    return (ind << 15) | (op << 11) | a;
  endfunction

  task automatic put(input int a, input int d);
    @(negedge clk);
    tb_we = 1'b1; tb_waddr = 11'(a); tb_wdata = 16'(d);
    m_mem[a] = d;
  endtask

  // behavioural model: one instruction, queueing its microaddress trace
  task automatic model_step();
    int ir, op, a, ea, ind, t;
    ir = m_mem[m_pc];
    m_pc = (m_pc + 1) & 'h7FF;
    uq.push_back(64); uq.push_back(65); uq.push_back(66);
    op  = (ir >> 11) & 'hF;
    ind = (ir >> 15) & 1;
    a   = ir & 'h7FF;
    ea  = ind ? (m_mem[a] & 'h7FF) : a;
    last_req = ind ? "R7" : "R3";
    case (op)
      0: begin
        uq.push_back(0);
        if (ind != 0) begin uq.push_back(67); uq.push_back(68); end
        uq.push_back(1); uq.push_back(2);
        m_ac = (m_ac + m_mem[ea]) & 'hFFFF;
      end
      1: begin
        uq.push_back(4);
        if (((m_ac >> 15) & 1) != 0) begin
          uq.push_back(6);
          if (ind != 0) begin uq.push_back(67); uq.push_back(68); end
          uq.push_back(7);
          m_pc = ea;
        end else uq.push_back(5);
        if (ind == 0) last_req = "R4";
      end
      2: begin
        uq.push_back(8);
        if (ind != 0) begin uq.push_back(67); uq.push_back(68); end
        uq.push_back(9); uq.push_back(10);
        m_mem[ea] = m_ac;
        if (ind == 0) last_req = "R5";
      end
      default: begin
        uq.push_back(12);
        if (ind != 0) begin uq.push_back(67); uq.push_back(68); end
        uq.push_back(13); uq.push_back(14); uq.push_back(15);
        t = m_mem[ea]; m_mem[ea] = m_ac; m_ac = t;
        if (ind == 0) last_req = "R6";
      end
    endcase
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog R2 actual=0 expected=1");
    summary();
  end

  initial begin
    int e;
    for (int i = 0; i < 2048; i++) m_mem[i] = 0;
    repeat (2) @(negedge clk);
    #1;
    chk(uaddr_o == 7'd64, "R1 uaddr in reset", uaddr_o, 64);
    chk(ac_o == 16'd0, "R1 ac in reset", ac_o, 0);
    chk(pc_o == 11'd0, "R1 pc in reset", pc_o, 0);
    // program
    put(0,  enc(0, 0, 100));   // add 5
    put(1,  enc(1, 0, 101));   // add via pointer with junk high bits
    put(2,  enc(0, 2, 103));   // store
    put(3,  enc(0, 3, 104));   // swap
    put(4,  enc(0, 1, 50));    // branch, positive: not taken
    put(5,  enc(0, 0, 105));   // add 0xFFFF: wraps
    put(6,  enc(0, 0, 106));   // add 0x9000: negative
    put(7,  enc(1, 2, 107));   // store indirect
    put(8,  enc(1, 3, 108));   // swap indirect
    put(9,  enc(0, 0, 112));   // add 0x8000
    put(10, enc(1, 1, 109));   // branch indirect, taken to 20
    put(20, enc(0, 1, 20));    // branch to self forever
    put(100, 5);      put(101, 'hF866); put(102, 7);
    put(103, 0);      put(104, 'h1234); put(105, 'hFFFF);
    put(106, 'h9000); put(107, 110);    put(108, 111);
    put(109, 20);     put(110, 0);      put(111, 'h0042);
    put(112, 'h8000);
    @(negedge clk);
    tb_we = 1'b0;
    tb_raddr = 11'd101; #1;
    chk(tb_rdata == 16'hF866, "R8 preload readback", tb_rdata, 'hF866);
    tb_raddr = 11'd1; #1;
    chk(tb_rdata == 16'(enc(1, 0, 101)), "R8 preload readback", tb_rdata, enc(1, 0, 101));
    @(negedge clk);
    rst_n = 1'b1;
    for (int cyc = 0; cyc < 400; cyc++) begin
      #1;
      if (uq.size() == 0) begin
        chk(int'(ac_o) == m_ac, {last_req, " ac at boundary"}, ac_o, m_ac);
        chk(int'(pc_o) == m_pc, {last_req, " pc at boundary"}, pc_o, m_pc);
        model_step();
      end
      e = uq.pop_front();
      chk(int'(uaddr_o) == e, "R2 microaddress", uaddr_o, e);
      @(negedge clk);
    end
    // final memory image
    for (int a = 100; a <= 112; a++) begin
      tb_raddr = 11'(a); #1;
      chk(int'(tb_rdata) == m_mem[a],
          (a == 103) ? "R5 stored word" : (a == 104) ? "R6 swapped word" :
          (a == 110 || a == 111) ? "R7 indirect target" : "R8 untouched word",
          tb_rdata, m_mem[a]);
    end
    chk(m_mem[103] == 12 && m_mem[104] == 12 && m_mem[110] == 'hA233 &&
        m_mem[111] == 'hA233, "R3 model sanity", m_mem[110], 'hA233);
    chk(int'(pc_o) == 20 || int'(pc_o) == 21, "R4 final loop pc", pc_o, 20);
    chk(ac_o == 16'h8042, "R3 final ac", ac_o, 'h8042);
    summary();
  end
endmodule